// File: doc/BRIEF.md
# Triple-Lane Median Select Monitor

The block sits behind three redundant computing lanes that each produce a signed result from the same synchronised input frame. On every frame strobe it takes the median of the three results as the command value. A single wild lane therefore never reaches the output, even before it has been identified. The block reports which lane supplied the median, which makes that lane the commanding lane and leaves the other two monitoring it.

Each lane is also compared with the median against a programmable threshold. A lane that stays outside the threshold for three frames in a row is flagged as faulty. The flag stays set until software or a supervisor pulses that lane's clear input.

With one lane flagged, the faulty lane is excluded and the output becomes the floored mean of the two healthy lanes. With two or more lanes flagged, no trustworthy value exists and the block raises an error instead. All outputs are registered and change on the clock edge that samples the frame strobe.

Top module: `tri_lane_median_sel`

## Requirements
- R1: With no lane flagged, `sel_val` is the median of the three signed lane values of the frame.
- R2: With no lane flagged, `cmd_lane` is the lowest lane index whose value equals the median. The encoding is 0, 1 or 2 for the lane, and 3 for no lane.
- R3: A lane disagrees when the absolute difference between its value and the three-lane median is strictly greater than `diff_thr`, taken as unsigned; a difference equal to the threshold agrees. An agreeing frame restarts that lane's run of disagreements.
- R4: A lane's flag in `flt_flag` is set by the third consecutive disagreeing frame, and it is visible in the same output update as that frame.
- R5: A set flag stays set through agreeing frames until bit i of `flt_clr` is high at a clock edge. The clear also restarts the run, and it wins over a set or a held flag in that same cycle.
- R6: With exactly one lane flagged, `sel_val` is the mean of the two other lanes, rounded toward negative infinity. `cmd_lane` is the lower index of the two healthy lanes.
- R7: With two or more lanes flagged, `no_valid_err` is 1, `sel_val` is 0 and `cmd_lane` is 3. Otherwise `no_valid_err` is 0.
- R8: The choice among median, mean and error for a frame uses the flags as they stood before that frame's own update.
- R9: `sel_val`, `cmd_lane` and `no_valid_err` change only on an edge where `frame_vld` is high. `out_vld` is high for exactly the one cycle that follows such an edge.
- R10: After reset, `sel_val` is 0, `cmd_lane` is 3, and `flt_flag`, `no_valid_err` and `out_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | Strobe: the three lane values belong to one frame |
| lane0_val | input | 16 | Signed result of lane 0 |
| lane1_val | input | 16 | Signed result of lane 1 |
| lane2_val | input | 16 | Signed result of lane 2 |
| diff_thr | input | 16 | Unsigned disagreement threshold |
| flt_clr | input | 3 | Per-lane fault flag clear |
| sel_val | output | 16 | Selected signed command value |
| cmd_lane | output | 2 | Commanding lane index, 3 when none |
| out_vld | output | 1 | One-cycle pulse after each frame update |
| flt_flag | output | 3 | Per-lane sticky fault flags |
| no_valid_err | output | 1 | Two or more lanes flagged, no output value |

## Verification
The assertions assume that `frame_vld`, the lane values, `diff_thr` and `flt_clr` are held steady and free of unknowns around each sampling edge. They also assume that reset is applied before the first frame. The stimulus sets every input on the falling clock edge and holds it for a full cycle. It compares results only on the following falling edge. The fault runs are built from frames chosen so that the median and each lane's distance to it are known in advance, including a distance exactly equal to the threshold.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int NUM_LANES = 3;
  typedef logic [1:0] lane_idx_t;
  localparam lane_idx_t LANE_NONE = 2'd3;
endpackage

// File: rtl/tlm_median3.sv
module tlm_median3
  import tlm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic signed [W-1:0] c_i,
  output logic signed [W-1:0] med_o,
  output lane_idx_t           med_idx_o
);
  logic signed [W-1:0] lo_ab, hi_ab, cap_c;

  always_comb begin
    lo_ab = (a_i < b_i) ? a_i : b_i;
    hi_ab = (a_i < b_i) ? b_i : a_i;
    cap_c = (c_i < hi_ab) ? c_i : hi_ab;
    med_o = (lo_ab > cap_c) ? lo_ab : cap_c;
    if (a_i == med_o)      med_idx_o = 2'd0;
    else if (b_i == med_o) med_idx_o = 2'd1;
    else                   med_idx_o = 2'd2;
  end

  // The median lies between the two others, counted by ordering relations.
  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      AST_MED_RANK: assert ((32'(a_i <= med_o) + 32'(b_i <= med_o) + 32'(c_i <= med_o)) >= 2 &&
                            (32'(a_i >= med_o) + 32'(b_i >= med_o) + 32'(c_i >= med_o)) >= 2); // R1
    end
  end
endmodule

// File: rtl/tlm_lane_health.sv
module tlm_lane_health #(
  parameter int W       = 16,
  parameter int PERSIST = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_vld,
  input  logic signed [W-1:0] val_i,
  input  logic signed [W-1:0] med_i,
  input  logic        [W-1:0] thr_i,
  input  logic                clr_i,
  output logic                flag_o
);
  localparam int CW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(PERSIST);

  logic signed [W:0] diff;
  logic        [W:0] mag;
  logic              dis;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              flag_q, flag_d;

  always_comb begin
    diff = {val_i[W-1], val_i} - {med_i[W-1], med_i};
    mag  = diff[W] ? $unsigned(-diff) : $unsigned(diff);
    dis  = mag > {1'b0, thr_i};
  end

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr_i) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (frame_vld) begin
      if (dis) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (cnt_q >= CNT_MAX - 1'b1) flag_d = 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_i |=> flag_q); // R5
  AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(frame_vld && dis && !clr_i && cnt_q == CNT_MAX - 1'b1)); // R4
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_q); // R5
endmodule

// File: rtl/tlm_out_sel.sv
module tlm_out_sel
  import tlm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic signed [W-1:0] c_i,
  input  logic        [2:0]   flags_i,
  input  logic signed [W-1:0] med_i,
  input  lane_idx_t           med_idx_i,
  output logic signed [W-1:0] val_o,
  output lane_idx_t           cmd_o,
  output logic                err_o
);
  function automatic logic signed [W-1:0] floor_mean(input logic signed [W-1:0] x,
                                                      input logic signed [W-1:0] y);
    logic signed [W:0] s;
    s = {x[W-1], x} + {y[W-1], y};
    return s[W:1];
  endfunction

  always_comb begin
    val_o = '0;
    cmd_o = LANE_NONE;
    err_o = 1'b0;
    unique case (flags_i)
      3'b000: begin
        val_o = med_i;
        cmd_o = med_idx_i;
      end
      3'b001: begin
        val_o = floor_mean(b_i, c_i);
        cmd_o = 2'd1;
      end
      3'b010: begin
        val_o = floor_mean(a_i, c_i);
        cmd_o = 2'd0;
      end
      3'b100: begin
        val_o = floor_mean(a_i, b_i);
        cmd_o = 2'd0;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tri_lane_median_sel.sv
module tri_lane_median_sel
  import tlm_pkg::*;
#(
  parameter int W       = 16,
  parameter int PERSIST = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_vld,
  input  logic signed [W-1:0] lane0_val,
  input  logic signed [W-1:0] lane1_val,
  input  logic signed [W-1:0] lane2_val,
  input  logic        [W-1:0] diff_thr,
  input  logic        [2:0]   flt_clr,
  output logic signed [W-1:0] sel_val,
  output logic        [1:0]   cmd_lane,
  output logic                out_vld,
  output logic        [2:0]   flt_flag,
  output logic                no_valid_err
);
  logic signed [W-1:0] lane_v [NUM_LANES];
  logic signed [W-1:0] med;
  lane_idx_t           med_idx;
  logic        [2:0]   flags;
  logic signed [W-1:0] val_d, val_q;
  lane_idx_t           cmd_d, cmd_q;
  logic                err_d, err_q, vld_q;

  assign lane_v[0] = lane0_val;
  assign lane_v[1] = lane1_val;
  assign lane_v[2] = lane2_val;

  tlm_median3 #(.W(W)) u_med (
    .a_i(lane0_val), .b_i(lane1_val), .c_i(lane2_val),
    .med_o(med), .med_idx_o(med_idx)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_health
    tlm_lane_health #(.W(W), .PERSIST(PERSIST)) u_health (
      .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
      .val_i(lane_v[g]), .med_i(med), .thr_i(diff_thr),
      .clr_i(flt_clr[g]), .flag_o(flags[g])
    );
  end

  logic signed [W-1:0] sel_nxt;
  lane_idx_t           cmd_nxt;
  logic                err_nxt;

  tlm_out_sel #(.W(W)) u_sel (
    .a_i(lane0_val), .b_i(lane1_val), .c_i(lane2_val),
    .flags_i(flags), .med_i(med), .med_idx_i(med_idx),
    .val_o(sel_nxt), .cmd_o(cmd_nxt), .err_o(err_nxt)
  );

  always_comb begin
    val_d = val_q;
    cmd_d = cmd_q;
    err_d = err_q;
    if (frame_vld) begin
      val_d = sel_nxt;
      cmd_d = cmd_nxt;
      err_d = err_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      cmd_q <= LANE_NONE;
      err_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      val_q <= val_d;
      cmd_q <= cmd_d;
      err_q <= err_d;
      vld_q <= frame_vld;
    end
  end

  assign sel_val      = val_q;
  assign cmd_lane     = cmd_q;
  assign no_valid_err = err_q;
  assign out_vld      = vld_q;
  assign flt_flag     = flags;

  AST_ERR_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld && $countones(flags) >= 2 |=> no_valid_err); // R7
  AST_ERR_ONLY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld && $countones(flags) < 2 |=> !no_valid_err); // R7
  AST_CMD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !no_valid_err |-> cmd_lane != LANE_NONE); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(sel_val) && $stable(cmd_lane) && !out_vld); // R9
  AST_CLEAN_MEDIAN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld && flags == 3'b000 |=> sel_val == $past(med)); // R1
endmodule

// File: tb/tri_lane_median_sel_tb.sv
module tri_lane_median_sel_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_vld;
  logic signed [15:0] l0, l1, l2;
  logic [15:0] thr;
  logic [2:0] clr;
  logic signed [15:0] sel_val;
  logic [1:0] cmd_lane;
  logic out_vld, no_valid_err;
  logic [2:0] flt_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tri_lane_median_sel u_dut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
    .lane0_val(l0), .lane1_val(l1), .lane2_val(l2),
    .diff_thr(thr), .flt_clr(clr),
    .sel_val(sel_val), .cmd_lane(cmd_lane), .out_vld(out_vld),
    .flt_flag(flt_flag), .no_valid_err(no_valid_err)
  );

  // columns: lane0, lane1, lane2, expected value, expected command lane
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{5, 5, 5, 5, 0},
    '{3, 7, 7, 7, 1},
    '{7, 3, 7, 7, 0},
    '{9, 2, 2, 2, 1},
    '{-32768, 32767, 0, 0, 2},
    '{-5, -9, -7, -7, 2},
    '{32767, 32767, -32768, 32767, 0},
    '{1, -1, 0, 0, 2}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int a, input int b, input int c, input logic [2:0] cl);
    @(negedge clk);
    l0 = 16'(a); l1 = 16'(b); l2 = 16'(c);
    clr = cl;
    frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    clr = 3'b000;
  endtask

  task automatic check_out(input string req, input int v, input int cmd, input int err);
    chk(req, int'(sel_val), v);
    chk(req, int'(cmd_lane), cmd);
    chk(req, int'(no_valid_err), err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_vld = 1'b0; l0 = '0; l1 = '0; l2 = '0;
    thr = 16'hFFFF; clr = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 val", int'(sel_val), 0);
    chk("R10 cmd", int'(cmd_lane), 3);
    chk("R10 flags", int'(flt_flag), 0);
    chk("R10 err", int'(no_valid_err), 0);
    chk("R10 vld", int'(out_vld), 0);

    // R1 R2 table walk, threshold so wide that no lane ever disagrees
    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][0], VEC[i][1], VEC[i][2], 3'b000);
      chk("R1 median", int'(sel_val), int'($signed(16'(VEC[i][3]))));
      chk("R2 cmd", int'(cmd_lane), VEC[i][4]);
      chk("R9 vld pulse", int'(out_vld), 1);
    end
    @(negedge clk);
    chk("R9 vld drops", int'(out_vld), 0);
    chk("R9 held", int'(sel_val), 0);

    // R3 threshold and run restart
    thr = 16'd10;
    frame(100, 110, 90, 3'b000);  // distances equal threshold: agree
    frame(100, 110, 90, 3'b000);
    frame(100, 110, 90, 3'b000);
    chk("R3 equal agrees", int'(flt_flag), 0);
    frame(100, 100, 120, 3'b000);
    frame(100, 100, 120, 3'b000);
    frame(100, 100, 100, 3'b000); // restarts lane 2 run
    frame(100, 100, 120, 3'b000);
    frame(100, 100, 120, 3'b000);
    chk("R3 run restarted", int'(flt_flag), 0);
    // R4 third consecutive disagreement; R8 output still median
    frame(100, 100, 120, 3'b000);
    chk("R4 flag set", int'(flt_flag), 3'b100);
    check_out("R8 pre-update flags", 100, 0, 0);

    // R6 one flag: floor mean of lanes 0 and 1
    frame(-3, 0, 5000, 3'b000);
    check_out("R6 floor mean", -2, 0, 0);
    // R5 sticky through agreeing frames
    frame(7, 7, 7, 3'b000);
    frame(7, 7, 7, 3'b000);
    chk("R5 sticky", int'(flt_flag), 3'b100);
    check_out("R6 mean agree", 7, 0, 0);

    // R5 clear without a frame; R9 outputs held
    @(negedge clk);
    clr = 3'b100;
    @(negedge clk);
    clr = 3'b000;
    chk("R5 cleared", int'(flt_flag), 0);
    chk("R9 no pulse", int'(out_vld), 0);
    chk("R9 val held", int'(sel_val), 7);
    frame(7, 8, 9, 3'b000);
    check_out("R1 after clear", 8, 1, 0);

    // R7 two lanes flagged
    frame(0, 1000, 500, 3'b000);
    frame(0, 1000, 500, 3'b000);
    frame(0, 1000, 500, 3'b000);
    chk("R4 two flags", int'(flt_flag), 3'b011);
    check_out("R8 median before err", 500, 2, 0);
    frame(1, 1, 1, 3'b000);
    check_out("R7 error", 0, 3, 1);
    // R5 clear wins over a held flag while the lane still disagrees
    frame(0, 1000, 500, 3'b001);
    chk("R5 clear wins", int'(flt_flag), 3'b010);
    check_out("R7 err this frame", 0, 3, 1);
    // R6 with lane 1 flagged: mean of lanes 0 and 2, cmd 0
    frame(-7, 1000, 4, 3'b000);
    check_out("R6 lane1 out", -2, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule